// File: doc/BRIEF.md
# SDRAM Command-Mode Override Controller

This block sits in front of an SDRAM controller's command path while the memory device is brought up. Software programs a command mode into a single 32-bit register. Until software selects normal decoding again, every memory access the host makes is turned into the one SDRAM command picked by that mode. The access may be a read or a write; the result is the same. Software therefore steps the device through its power-up sequence by writing a mode and then touching the memory: no-operation, precharge of all banks, auto-refresh, load of the mode register or the extended mode register, deep power-down or calibration, and the low-power mode-register command.

A newly programmed mode becomes active only on the next write access to the memory. Reads that come before that write still use the previous mode. An auto-refresh is refused with a one-cycle sequence-error pulse unless an all-banks precharge has been issued since the last normally decoded access. The register holds three fields: the mode, an 8-bit value that is placed on the address of the low-power mode-register command, and a read-only flag that shows whether device auto-initialization is running. A write-protect input blocks register writes.

In normal mode an access is handed, one cycle later, to a stub normal-access path. In every other mode a command is held on a valid/ready command bus until it is taken. The access port stays not-ready during that time.

Top module: `sdram_cmd_override`

## Requirements
- R1: After reset the register reads 0, the access port is ready, and no command, normal-path pulse or error pulse is produced.
- R2: The register reads as {16'h0, select[7:0] in bits 15:8, 3'b0, status in bit 4, 1'b0, mode[2:0] in bits 2:0}. Writes update only bits 15:8 and 2:0, and every other bit reads 0.
- R3: While `wp_en` is high, register writes change nothing, including which mode is pending. Reads still return the current contents.
- R4: Status bit 4 becomes 1 one cycle after an `init_start` pulse. It becomes 0 one cycle after an `init_done` or `lp_exit` pulse, and clearing wins over setting.
- R5: When the active mode is not 0, each accepted access (read or write) puts one command on the bus whose `cmd_op` equals the mode code: 1 no-op, 2 precharge all, 3 load mode register, 4 auto-refresh, 5 extended load mode register, 6 deep power-down/calibration, 7 low-power mode-register command.
- R6: A mode written to the register becomes active only on the first accepted write access that follows. That write access already uses the new mode, and any read access before it uses the previous active mode.
- R7: An access whose mode is 4 produces a one-cycle `seq_err` pulse and no command, unless a mode-2 command has been issued since reset and since the last access in mode 0.
- R8: For modes 1 through 6, `cmd_bank` and `cmd_addr` carry the bank and address of the triggering access, so an extended-load write selects its target register through its bank.
- R9: For mode 7, `cmd_addr` is the register's select field zero-extended to the address width, and `cmd_bank` is the access bank.
- R10: Each accepted access yields exactly one output event. While a command waits with `cmd_ready` low, `cmd_valid` and its fields hold and `acc_ready` stays low.
- R11: In mode 0 an accepted access gives a one-cycle `norm_valid` pulse on the next cycle, carrying its write flag, bank and address, and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| wp_en | input | 1 | Write-protect enable, blocks register writes |
| reg_rdata | output | 32 | Register read value |
| init_start | input | 1 | Pulse: auto-initialization began |
| init_done | input | 1 | Pulse: auto-initialization finished |
| lp_exit | input | 1 | Pulse: backup/low-power exit, clears status |
| acc_valid | input | 1 | Memory access request |
| acc_ready | output | 1 | Block can accept an access |
| acc_write | input | 1 | Access is a write |
| acc_bank | input | BANK_W | Access bank |
| acc_addr | input | ADDR_W | Access address |
| cmd_valid | output | 1 | Forced command present |
| cmd_ready | input | 1 | Command bus takes the command |
| cmd_op | output | 3 | Command opcode (mode code) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ADDR_W | Command address |
| norm_valid | output | 1 | Normal-path access pulse |
| norm_write | output | 1 | Normal-path write flag |
| norm_bank | output | BANK_W | Normal-path bank |
| norm_addr | output | ADDR_W | Normal-path address |
| seq_err | output | 1 | Refused refresh, one-cycle pulse |

## Verification
The assertions assume that the command bus never withdraws `cmd_ready` in a way that bears on the fields, that `acc_bank` and `acc_addr` stay steady while `acc_valid` is high, and that register writes are single-cycle strobes. The stimulus holds each access until `acc_ready` lets it through. It changes `cmd_ready` only just after a clock edge and applies the write-protect level across a whole register write. All accesses go through one driver, so there is never more than one access in flight at the port. This keeps the expected output order fixed for the scoreboard.

// File: rtl/sdram_cmd_override.sv
module sdram_cmd_override #(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              wp_en,
  output logic [31:0]       reg_rdata,
  input  logic              init_start,
  input  logic              init_done,
  input  logic              lp_exit,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              norm_valid,
  output logic              norm_write,
  output logic [BANK_W-1:0] norm_bank,
  output logic [ADDR_W-1:0] norm_addr,
  output logic              seq_err
);

  localparam logic [2:0] M_NORMAL = 3'd0;
  localparam logic [2:0] M_PREA   = 3'd2;
  localparam logic [2:0] M_REF    = 3'd4;
  localparam logic [2:0] M_LPMR   = 3'd7;
  localparam int         SEL_W    = 8;
  localparam int         PAD_W    = ADDR_W - SEL_W;

  logic [2:0]       mode_q, live_q;
  logic [SEL_W-1:0] sel_q;
  logic             pend_q, prea_q, stat_q;

  wire       accept  = acc_valid && acc_ready;
  wire [2:0] eff     = (pend_q && acc_write) ? mode_q : live_q;
  wire       blocked = (eff == M_REF) && !prea_q;
  wire       issue   = accept && (eff != M_NORMAL) && !blocked;

  assign acc_ready = !cmd_valid;
  assign reg_rdata = {16'h0, sel_q, 3'b000, stat_q, 1'b0, mode_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_NORMAL;
      live_q <= M_NORMAL;
      sel_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (accept && acc_write && pend_q) begin
        live_q <= mode_q;
        pend_q <= 1'b0;
      end
      if (reg_wr && !wp_en) begin
        mode_q <= reg_wdata[2:0];
        sel_q  <= reg_wdata[15:8];
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= 1'b0;
    else if (init_done || lp_exit) stat_q <= 1'b0;
    else if (init_start) stat_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prea_q <= 1'b0;
    else if (issue && eff == M_PREA) prea_q <= 1'b1;
    else if (accept && eff == M_NORMAL) prea_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
    end else if (issue) begin
      cmd_valid <= 1'b1;
      cmd_op    <= eff;
      cmd_bank  <= acc_bank;
      cmd_addr  <= (eff == M_LPMR) ? {{PAD_W{1'b0}}, sel_q} : acc_addr;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      norm_valid <= 1'b0;
      norm_write <= 1'b0;
      norm_bank  <= '0;
      norm_addr  <= '0;
      seq_err    <= 1'b0;
    end else begin
      norm_valid <= accept && eff == M_NORMAL;
      seq_err    <= accept && blocked;
      if (accept && eff == M_NORMAL) begin
        norm_write <= acc_write;
        norm_bank  <= acc_bank;
        norm_addr  <= acc_addr;
      end
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bank) && $stable(cmd_addr));
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !acc_ready);
  p_wp_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && wp_en |=> $stable(reg_rdata[15:8]) && $stable(reg_rdata[2:0]));
  p_err_no_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !cmd_valid && !norm_valid);
  p_norm_no_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    norm_valid |-> !cmd_valid);
  p_ref_after_prea_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_op == M_REF |-> prea_q);
  p_status_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !reg_rdata[4]);

endmodule

// File: tb/sdram_cmd_override_tb.sv
`timescale 1ns/1ps
module sdram_cmd_override_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, wp_en = 0, init_start = 0, init_done = 0, lp_exit = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic acc_valid = 0, acc_ready, acc_write = 0;
  logic [2:0] acc_bank = 0, cmd_bank, norm_bank, cmd_op;
  logic [13:0] acc_addr = 0, cmd_addr, norm_addr;
  logic cmd_valid, cmd_ready = 1, norm_valid, norm_write, seq_err;
  int n_tests = 0, n_fail = 0;

  typedef struct {
    int kind; logic [2:0] op; logic [2:0] bank; logic [13:0] addr; logic wr; string rq;
  } item_t;
  item_t expq[$];

  always #2.5 clk = ~clk;

  sdram_cmd_override dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .wp_en(wp_en),
    .reg_rdata(reg_rdata), .init_start(init_start), .init_done(init_done), .lp_exit(lp_exit),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write), .acc_bank(acc_bank),
    .acc_addr(acc_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .norm_valid(norm_valid), .norm_write(norm_write),
    .norm_bank(norm_bank), .norm_addr(norm_addr), .seq_err(seq_err));

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [31:0] exp, input string rq);
    @(negedge clk); check(reg_rdata == exp, rq, reg_rdata, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) init_start = 1; else if (which == 1) init_done = 1; else lp_exit = 1;
    @(posedge clk); #1 init_start = 0; init_done = 0; lp_exit = 0;
  endtask

  task automatic access(input logic w, input logic [2:0] b, input logic [13:0] a,
                        input int kind, input logic [2:0] op, input logic [13:0] ea, input string rq);
    item_t it;
    it.kind = kind; it.op = op; it.bank = b; it.addr = ea; it.wr = w; it.rq = rq;
    expq.push_back(it);
    @(negedge clk); acc_valid = 1; acc_write = w; acc_bank = b; acc_addr = a;
    while (!acc_ready) @(negedge clk);
    @(posedge clk); #1 acc_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int nev;
      nev = int'(cmd_valid && cmd_ready) + int'(norm_valid) + int'(seq_err);
      if (nev > 1) check(0, "R10 multiple events", nev, 1);
      if (nev == 1) begin
        if (expq.size() == 0) check(0, "R10 unexpected output", 32'(nev), 0);
        else begin
          item_t e;
          e = expq.pop_front();
          if (cmd_valid && cmd_ready)
            check(e.kind == 0 && cmd_op == e.op && cmd_bank == e.bank && cmd_addr == e.addr,
                  e.rq, {e.kind[3:0], 1'b0, cmd_op, 5'b0, cmd_bank, cmd_addr}, {4'd0, 1'b0, e.op, 5'b0, e.bank, e.addr});
          else if (norm_valid)
            check(e.kind == 1 && norm_write == e.wr && norm_bank == e.bank && norm_addr == e.addr,
                  e.rq, {e.kind[3:0], 3'b0, norm_write, 5'b0, norm_bank, norm_addr}, {4'd1, 3'b0, e.wr, 5'b0, e.bank, e.addr});
          else
            check(e.kind == 2, e.rq, e.kind, 2);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(reg_rdata == 0 && acc_ready && !cmd_valid && !norm_valid && !seq_err, "R1 reset state",
          reg_rdata, 0);
    // R11 normal pass-through
    access(1, 3'd2, 14'h123, 1, 0, 14'h123, "R11 normal write");
    access(0, 3'd5, 14'h0AA, 1, 0, 14'h0AA, "R11 normal read");
    // R2 layout and reserved bits
    wr_reg(32'hFFFF_FFFF);
    rd_reg(32'h0000_FF07, "R2 reserved bits zero");
    wr_reg(32'h0000_0001);
    rd_reg(32'h0000_0001, "R2 mode field");
    // R6 arming
    access(0, 3'd1, 14'h010, 1, 0, 14'h010, "R6 read before arming uses old mode");
    access(1, 3'd1, 14'h020, 0, 1, 14'h020, "R6 arming write issues NOP");
    access(0, 3'd4, 14'h030, 0, 1, 14'h030, "R5 read issues NOP");
    // R3 write protect
    wp_en = 1;
    wr_reg(32'h0000_0002);
    rd_reg(32'h0000_0001, "R3 protected write ignored");
    wp_en = 0;
    access(1, 3'd0, 14'h040, 0, 1, 14'h040, "R3 mode unchanged after protected write");
    // R7 refresh ordering
    wr_reg(32'h0000_0004);
    access(1, 3'd0, 14'h000, 2, 0, 0, "R7 refresh without precharge refused");
    wr_reg(32'h0000_0002);
    access(1, 3'd0, 14'h400, 0, 2, 14'h400, "R5 precharge all");
    wr_reg(32'h0000_0004);
    access(1, 3'd0, 14'h000, 0, 4, 14'h000, "R7 refresh after precharge");
    access(0, 3'd0, 14'h000, 0, 4, 14'h000, "R7 second refresh");
    wr_reg(32'h0000_0003);
    access(1, 3'd0, 14'h033, 0, 3, 14'h033, "R5 load mode register");
    // R8 extended load bank
    wr_reg(32'h0000_0005);
    access(1, 3'd3, 14'h456, 0, 5, 14'h456, "R8 extended load bank forwarded");
    // R9 low-power MR command
    wr_reg(32'h0000_3C07);
    rd_reg(32'h0000_3C07, "R2 select field readback");
    access(1, 3'd1, 14'h7FF, 0, 7, 14'h03C, "R9 select on address");
    // R10 stall
    repeat (3) @(negedge clk);
    @(posedge clk); #1 cmd_ready = 0;
    access(0, 3'd2, 14'h111, 0, 7, 14'h03C, "R10 stalled command once");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!acc_ready && cmd_valid && cmd_op == 3'd7, "R10 held while stalled",
            {acc_ready, cmd_valid}, 2'b01);
    end
    @(posedge clk); #1 cmd_ready = 1;
    // R4 status flag
    pulse(0); rd_reg(32'h0000_3C17, "R4 status set");
    pulse(1); rd_reg(32'h0000_3C07, "R4 status cleared by done");
    pulse(0); rd_reg(32'h0000_3C17, "R4 status set again");
    pulse(2); rd_reg(32'h0000_3C07, "R4 status cleared by exit");
    // R7 precharge record cleared by normal access
    wr_reg(32'h0000_0000);
    access(1, 3'd6, 14'h099, 1, 0, 14'h099, "R11 back to normal");
    wr_reg(32'h0000_0004);
    access(1, 3'd0, 14'h000, 2, 0, 0, "R7 refresh refused after normal access");
    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R10 all events seen", expq.size(), 0);
    check(!cmd_valid && !norm_valid && !seq_err, "R10 idle at end", {cmd_valid, norm_valid, seq_err}, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule